// File: doc/BRIEF.md
# Command Method Macro Dispatcher

This block sits on a stream of command method writes. Each write carries a method number, a 32-bit argument and a flag that marks the last write of a burst. Methods below a fixed threshold are ordinary register writes. The block forwards them one cycle later on a register write port. A few of these low methods also act inside the block. One sets the code upload address. One stores a code word at that address and then moves the address up by one. One selects a macro entry number. One binds a code offset to the selected entry.

Methods at or above the threshold are macro triggers, and they come in even/odd pairs. The even method of a pair opens a macro call. The odd method that follows it carries further arguments. Every accepted trigger or argument word goes into a parameter buffer. When the last-call flag arrives, the block looks up the code offset bound to the entry and raises a launch request. The request carries that offset and the number of gathered words. The execution engine reads the words through a random-access read port and signals completion. Only then is the buffer released. Illegal sequences set sticky error flags.

The controller is a four-state machine:
- `ST_IDLE`: accepts plain writes and even triggers.
- `ST_GATHER`: a macro is pending, and only its argument method is legal.
- `ST_LAUNCH`: the request is held until it is accepted.
- `ST_RUN`: the block waits for completion, and input is stalled.

Transitions:
- start: `ST_IDLE` to `ST_GATHER`.
- fire: `ST_IDLE` or `ST_GATHER` to `ST_LAUNCH`.
- miss: `ST_IDLE` or `ST_GATHER` to `ST_IDLE`.
- accept: `ST_LAUNCH` to `ST_RUN`.
- finish: `ST_RUN` to `ST_IDLE`.

Top module: `macro_dispatch`

## Requirements
- R1: A method below 0xE00, accepted in `ST_IDLE`, appears on `reg_we`/`reg_addr`/`reg_data` on the next clock edge for exactly one cycle.
- R2: In `ST_IDLE`, an even method m ≥ 0xE00 opens a macro call for entry (m − 0xE00) >> 1. An odd method ≥ 0xE00 in `ST_IDLE` is dropped and sets `err[1]`.
- R3: Each accepted trigger or argument write appends its argument to the parameter buffer. `prm_data` at index i returns the i-th stored word. `mac_count` equals the number of stored words.
- R4: While a macro is pending, only the pending method plus one is accepted. Any other write is dropped, sets `err[0]` and leaves the call pending.
- R5: An accepted trigger or argument write with `in_last` raises `mac_valid` on the next edge. `mac_valid` holds with a stable offset and count until `mac_ready`. After that, `in_ready` stays low and input is ignored until `mac_done`. The block then returns to `ST_IDLE` with an empty buffer.
- R6: Firing an entry that has no binding, or an entry ≥ NUM_ENTRIES (32), sets `err[2]`. In that case `mac_valid` is not raised, the buffer is emptied and the block returns to `ST_IDLE`.
- R7: A write to method 0x047 sets the bind select value. A write to method 0x048 binds arg[5:0] as the code offset of the selected entry, or does nothing if the selection is ≥ 32. `mac_offset` carries the bound offset of the fired entry.
- R8: A write to method 0x045 sets the upload address. Each write to method 0x046 stores the argument at that address, readable on `code_data`, and then increments the address. If the address is ≥ CODE_DEPTH (64), nothing is stored, the address is unchanged and `err[3]` is set.
- R9: The parameter buffer holds 32 words. A further argument is dropped, sets `err[4]`, and leaves `mac_count` at 32.
- R10: The error flags are sticky until reset. After reset, `err` = 0, `in_ready` = 1, `mac_valid` = 0 and `reg_we` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A method write is presented |
| in_ready | output | 1 | The block accepts method writes (`ST_IDLE`/`ST_GATHER`) |
| in_method | input | 12 | Method number |
| in_arg | input | 32 | Method argument |
| in_last | input | 1 | Last write of the burst |
| reg_we | output | 1 | Forwarded plain register write strobe |
| reg_addr | output | 12 | Forwarded register number |
| reg_data | output | 32 | Forwarded register value |
| mac_valid | output | 1 | Macro launch request |
| mac_ready | input | 1 | Launch request accepted |
| mac_offset | output | 6 | Code offset bound to the fired entry |
| mac_count | output | 6 | Number of gathered parameters |
| mac_done | input | 1 | Macro execution finished |
| prm_idx | input | 5 | Parameter read index |
| prm_data | output | 32 | Parameter word at `prm_idx` |
| code_addr | input | 6 | Code memory read address |
| code_data | output | 32 | Code word at `code_addr` |
| err | output | 5 | Sticky flags: [0] sequence, [1] odd start, [2] unbound, [3] upload range, [4] overflow |

## Verification
A wrong pending-method record or a wrong state shows up quickly at the ports. It appears on the very next clock edge as a spurious `err[0]`, as a plain write that leaks onto `reg_we`, or as a stray or missing `mac_valid`. A bad buffer count or a bad bind entry stays hidden until the call fires. At that point `mac_count`, `mac_offset` or `prm_data` differs from the reference queue in the first launch cycle. Upload address slips show up at the next `code_data` read or as a false `err[3]`.

// File: rtl/mdisp_pkg.sv
package mdisp_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_GATHER = 2'd1,
        ST_LAUNCH = 2'd2,
        ST_RUN    = 2'd3
    } mdisp_state_e;

    localparam int ERR_SEQ    = 0;
    localparam int ERR_ODD    = 1;
    localparam int ERR_NOBIND = 2;
    localparam int ERR_UPLOAD = 3;
    localparam int ERR_OVF    = 4;
    localparam int ERR_W      = 5;
endpackage

// File: rtl/mdisp_param_buf.sv
module mdisp_param_buf #(
    parameter int DW    = 32,
    parameter int DEPTH = 32,
    localparam int IW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] din,
    input  logic          clear,
    input  logic [IW-1:0] rd_idx,
    output logic [DW-1:0] rd_data,
    output logic [CW-1:0] count,
    output logic          ovf
);
    logic [DW-1:0] mem [DEPTH];
    logic          full;

    assign full    = (count == CW'(DEPTH));
    assign ovf     = push && full;
    assign rd_data = mem[rd_idx];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            count <= '0;
        else if (clear)        count <= '0;
        else if (push && !full) count <= count + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (push && !full && !clear) mem[count[IW-1:0]] <= din;
    end

    // R9
    full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !clear) |=> (count == CW'(DEPTH)));
endmodule

// File: rtl/mdisp_code_store.sv
module mdisp_code_store #(
    parameter int DW    = 32,
    parameter int DEPTH = 64,
    parameter int AW    = 16,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set_addr,
    input  logic [AW-1:0] addr_in,
    input  logic          wr,
    input  logic [DW-1:0] din,
    input  logic [IW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    output logic          oob
);
    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] up_addr;

    assign oob     = wr && (up_addr >= AW'(DEPTH));
    assign rd_data = mem[rd_addr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           up_addr <= '0;
        else if (set_addr)    up_addr <= addr_in;
        else if (wr && !oob)  up_addr <= up_addr + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (wr && !oob) mem[up_addr[IW-1:0]] <= din;
    end

    // R8
    oob_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oob |=> $stable(up_addr));
endmodule

// File: rtl/mdisp_bind_table.sv
module mdisp_bind_table #(
    parameter int ENTRIES = 32,
    parameter int OW      = 6,
    parameter int EW      = 11,
    localparam int BIW    = $clog2(ENTRIES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel_wr,
    input  logic [31:0]   sel_in,
    input  logic          off_wr,
    input  logic [OW-1:0] off_in,
    input  logic [EW-1:0] lk_entry,
    output logic          lk_hit,
    output logic [OW-1:0] lk_off
);
    logic [31:0]   sel_q;
    logic          bound_q [ENTRIES];
    logic [OW-1:0] off_q   [ENTRIES];
    logic          in_range;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      sel_q <= '0;
        else if (sel_wr) sel_q <= sel_in;
    end

    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                bound_q[g] <= 1'b0;
                off_q[g]   <= '0;
            end else if (off_wr && (sel_q == 32'(g))) begin
                bound_q[g] <= 1'b1;
                off_q[g]   <= off_in;
            end
        end
    end

    assign in_range = (int'(lk_entry) < ENTRIES);
    assign lk_hit   = in_range && bound_q[lk_entry[BIW-1:0]];
    assign lk_off   = off_q[lk_entry[BIW-1:0]];
endmodule

// File: rtl/macro_dispatch.sv
module macro_dispatch
    import mdisp_pkg::*;
#(
    parameter int METHOD_W                  = 12,
    parameter logic [METHOD_W-1:0] MACRO_BASE = 12'hE00,
    parameter int DW                        = 32,
    parameter int PARAM_DEPTH               = 32,
    parameter int CODE_DEPTH                = 64,
    parameter int NUM_ENTRIES               = 32,
    parameter int UP_AW                     = 16,
    parameter logic [METHOD_W-1:0] M_UP_ADDR  = 12'h045,
    parameter logic [METHOD_W-1:0] M_UP_DATA  = 12'h046,
    parameter logic [METHOD_W-1:0] M_BIND_SEL = 12'h047,
    parameter logic [METHOD_W-1:0] M_BIND_OFF = 12'h048,
    localparam int PIW = $clog2(PARAM_DEPTH),
    localparam int PCW = $clog2(PARAM_DEPTH + 1),
    localparam int CAW = $clog2(CODE_DEPTH),
    localparam int EW  = METHOD_W - 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [METHOD_W-1:0] in_method,
    input  logic [DW-1:0]       in_arg,
    input  logic                in_last,
    output logic                reg_we,
    output logic [METHOD_W-1:0] reg_addr,
    output logic [DW-1:0]       reg_data,
    output logic                mac_valid,
    input  logic                mac_ready,
    output logic [CAW-1:0]      mac_offset,
    output logic [PCW-1:0]      mac_count,
    input  logic                mac_done,
    input  logic [PIW-1:0]      prm_idx,
    output logic [DW-1:0]       prm_data,
    input  logic [CAW-1:0]      code_addr,
    output logic [DW-1:0]       code_data,
    output logic [ERR_W-1:0]    err
);
    mdisp_state_e        state, state_nx;
    logic [METHOD_W-1:0] pend_m;
    logic [CAW-1:0]      off_q;
    logic                accept, is_macro, arg_match;
    logic                plain_wr, start, odd_err, seq_err, arg_wr, push, fire, miss;
    logic                buf_clear, buf_ovf, up_oob, lk_hit;
    logic [CAW-1:0]      lk_off;
    logic [EW-1:0]       entry;
    logic [METHOD_W-1:0] rel_m;

    // Method classification
    assign accept    = in_valid && in_ready;
    assign is_macro  = (in_method >= MACRO_BASE);
    assign rel_m     = in_method - MACRO_BASE;
    assign entry     = rel_m[METHOD_W-1:1];
    assign arg_match = (in_method == pend_m + 1'b1);

    assign plain_wr  = accept && (state == ST_IDLE) && !is_macro;
    assign start     = accept && (state == ST_IDLE) && is_macro && !in_method[0];
    assign odd_err   = accept && (state == ST_IDLE) && is_macro && in_method[0];
    assign arg_wr    = accept && (state == ST_GATHER) && arg_match;
    assign seq_err   = accept && (state == ST_GATHER) && !arg_match;
    assign push      = start || arg_wr;
    assign fire      = push && in_last;
    assign miss      = fire && !lk_hit;
    assign buf_clear = miss || ((state == ST_RUN) && mac_done);

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (start) state_nx = !in_last ? ST_GATHER : (lk_hit ? ST_LAUNCH : ST_IDLE);
            ST_GATHER: if (fire)  state_nx = lk_hit ? ST_LAUNCH : ST_IDLE;
            ST_LAUNCH: if (mac_ready) state_nx = ST_RUN;
            ST_RUN:    if (mac_done)  state_nx = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_m   <= '0;
            off_q    <= '0;
            reg_we   <= 1'b0;
            reg_addr <= '0;
            reg_data <= '0;
            err      <= '0;
        end else begin
            if (start) pend_m <= in_method;
            if (fire)  off_q  <= lk_off;
            reg_we <= plain_wr;
            if (plain_wr) begin
                reg_addr <= in_method;
                reg_data <= in_arg;
            end
            err[ERR_SEQ]    <= err[ERR_SEQ]    | seq_err;
            err[ERR_ODD]    <= err[ERR_ODD]    | odd_err;
            err[ERR_NOBIND] <= err[ERR_NOBIND] | miss;
            err[ERR_UPLOAD] <= err[ERR_UPLOAD] | up_oob;
            err[ERR_OVF]    <= err[ERR_OVF]    | buf_ovf;
        end
    end

    // Outputs
    always_comb begin
        in_ready   = (state == ST_IDLE) || (state == ST_GATHER);
        mac_valid  = (state == ST_LAUNCH);
        mac_offset = off_q;
    end

    mdisp_param_buf #(.DW(DW), .DEPTH(PARAM_DEPTH)) u_pbuf (
        .clk(clk), .rst_n(rst_n), .push(push), .din(in_arg), .clear(buf_clear),
        .rd_idx(prm_idx), .rd_data(prm_data), .count(mac_count), .ovf(buf_ovf)
    );

    mdisp_code_store #(.DW(DW), .DEPTH(CODE_DEPTH), .AW(UP_AW)) u_code (
        .clk(clk), .rst_n(rst_n),
        .set_addr(plain_wr && (in_method == M_UP_ADDR)), .addr_in(in_arg[UP_AW-1:0]),
        .wr(plain_wr && (in_method == M_UP_DATA)), .din(in_arg),
        .rd_addr(code_addr), .rd_data(code_data), .oob(up_oob)
    );

    mdisp_bind_table #(.ENTRIES(NUM_ENTRIES), .OW(CAW), .EW(EW)) u_bind (
        .clk(clk), .rst_n(rst_n),
        .sel_wr(plain_wr && (in_method == M_BIND_SEL)), .sel_in(in_arg),
        .off_wr(plain_wr && (in_method == M_BIND_OFF)), .off_in(in_arg[CAW-1:0]),
        .lk_entry(entry), .lk_hit(lk_hit), .lk_off(lk_off)
    );

    // R5
    launch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mac_valid && !mac_ready) |=> (mac_valid && $stable(mac_offset) && $stable(mac_count)));

    // R5
    busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_RUN) && in_valid) |=> !reg_we);

    // R4
    seq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_GATHER) && in_valid && !arg_match) |=> ((state == ST_GATHER) && !reg_we));

    // R10
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err != '0) |=> ((err & $past(err)) == $past(err)));
endmodule

// File: tb/test_macro_dispatch.sv
module test_macro_dispatch;
    localparam int BASE = 'hE00;
    localparam int UPA  = 'h045;
    localparam int UPD  = 'h046;
    localparam int BSEL = 'h047;
    localparam int BOFF = 'h048;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        in_valid = 1'b0, in_last = 1'b0, mac_ready = 1'b0, mac_done = 1'b0;
    logic [11:0] in_method = '0;
    logic [31:0] in_arg = '0;
    logic [4:0]  prm_idx = '0;
    logic [5:0]  code_addr = '0;
    logic        in_ready, reg_we, mac_valid;
    logic [11:0] reg_addr;
    logic [31:0] reg_data, prm_data, code_data;
    logic [5:0]  mac_offset, mac_count;
    logic [4:0]  err;

    int tests = 0, fails = 0;
    bit finished = 1'b0;

    macro_dispatch i_macro_dispatch (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_method(in_method), .in_arg(in_arg), .in_last(in_last),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_data(reg_data),
        .mac_valid(mac_valid), .mac_ready(mac_ready), .mac_offset(mac_offset),
        .mac_count(mac_count), .mac_done(mac_done), .prm_idx(prm_idx),
        .prm_data(prm_data), .code_addr(code_addr), .code_data(code_data), .err(err)
    );

    always #10 clk = ~clk;

    // Behavioural reference model
    int          m_st, m_pend, m_up, m_off, m_e, m_m;
    logic [31:0] m_bsel;
    logic [4:0]  m_err;
    bit          m_we;
    int          m_wa;
    logic [31:0] m_wd;
    logic [31:0] q[$];
    logic [31:0] m_code [64];
    bit          m_bound [32];
    int          m_boff [32];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_pend = 0; m_up = 0; m_off = 0; m_bsel = 0; m_err = 0; m_we = 0;
            q.delete();
            foreach (m_bound[k]) begin m_bound[k] = 0; m_boff[k] = 0; end
        end else begin
            m_we = 0;
            if (m_st == 2) begin
                if (mac_ready) m_st = 3;
            end else if (m_st == 3) begin
                if (mac_done) begin m_st = 0; q.delete(); end
            end else if (in_valid) begin
                m_m = int'(in_method);
                if (m_st == 1 && m_m != m_pend + 1) m_err[0] = 1;
                else if (m_st == 0 && m_m < BASE) begin
                    m_we = 1; m_wa = m_m; m_wd = in_arg;
                    if (m_m == UPA) m_up = int'(in_arg[15:0]);
                    if (m_m == UPD) begin
                        if (m_up < 64) begin m_code[m_up] = in_arg; m_up++; end
                        else m_err[3] = 1;
                    end
                    if (m_m == BSEL) m_bsel = in_arg;
                    if (m_m == BOFF && m_bsel < 32) begin
                        m_bound[m_bsel] = 1; m_boff[m_bsel] = int'(in_arg[5:0]);
                    end
                end else if (m_st == 0 && m_m[0]) m_err[1] = 1;
                else begin
                    if (m_st == 0) m_pend = m_m;
                    if (q.size() < 32) q.push_back(in_arg); else m_err[4] = 1;
                    if (in_last) begin
                        m_e = (m_m - BASE) >> 1;
                        if (m_e < 32 && m_bound[m_e]) begin m_st = 2; m_off = m_boff[m_e]; end
                        else begin m_err[2] = 1; m_st = 0; q.delete(); end
                    end else m_st = 1;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk(in_ready == (m_st < 2), "R5 in_ready", in_ready, m_st < 2);
            chk(mac_valid == (m_st == 2), "R5 mac_valid", mac_valid, m_st == 2);
            if (m_st == 2) begin
                chk(mac_offset == m_off, "R7 mac_offset", mac_offset, m_off);
                chk(mac_count == q.size(), "R3 mac_count", mac_count, q.size());
            end
            chk(err == m_err, "R10 err", err, m_err);
            chk(reg_we == m_we, "R1 reg_we", reg_we, m_we);
            if (m_we) begin
                chk(reg_addr == m_wa, "R1 reg_addr", reg_addr, m_wa);
                chk(reg_data == m_wd, "R1 reg_data", reg_data, m_wd);
            end
        end
    end

    task automatic put(input int m, input logic [31:0] a, input bit l);
        @(negedge clk);
        in_valid = 1; in_method = 12'(m); in_arg = a; in_last = l;
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 0; in_last = 0;
    endtask

    task automatic check_params();
        #1;
        for (int i = 0; i < q.size(); i++) begin
            prm_idx = 5'(i); #1;
            chk(prm_data == q[i], "R3 prm_data", prm_data, q[i]);
        end
    endtask

    task automatic run_macro(input int hold);
        repeat (hold) @(negedge clk);
        #1 chk(mac_valid == 1, "R5 held", mac_valid, 1);
        check_params();
        @(negedge clk) mac_ready = 1;
        @(negedge clk) mac_ready = 0;
        put('h012, 32'hDEAD, 0);
        idle();
        #1 chk(reg_we == 0, "R5 ignored during run", reg_we, 0);
        @(negedge clk) mac_done = 1;
        @(negedge clk) mac_done = 0;
        #1 chk(in_ready == 1 && mac_count == 0, "R5 released", {in_ready, mac_count}, 7'h40);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1 chk(err == 0 && in_ready && !mac_valid && !reg_we, "R10 reset",
               {err, in_ready, mac_valid, reg_we}, 8'h04);
        rst_n = 1;
        // R1 plain writes
        put('h010, 32'h1111_2222, 0); put('h3FF, 32'hA5A5_0001, 1); idle();
        #1 chk(reg_we && reg_addr == 'h3FF, "R1 forward", reg_addr, 'h3FF);
        // R7 bind entry 3 -> offset 5, entry 9 -> offset 40
        put(BSEL, 3, 0); put(BOFF, 32'hFFFF_FF05, 0);
        put(BSEL, 9, 0); put(BOFF, 40, 0); put(BSEL, 100, 0); put(BOFF, 7, 0); idle();
        // R8 upload
        put(UPA, 0, 0); put(UPD, 32'hC0DE_0000, 0); put(UPD, 32'hC0DE_0001, 0);
        put(UPD, 32'hC0DE_0002, 0); idle();
        for (int i = 0; i < 3; i++) begin
            code_addr = 6'(i); #1;
            chk(code_data == m_code[i], "R8 code_data", code_data, m_code[i]);
        end
        put(UPA, 63, 0); put(UPD, 32'hC0DE_003F, 0); put(UPD, 32'hBAD0_0000, 0); idle();
        code_addr = 63; #1;
        chk(code_data == 32'hC0DE_003F && err[3], "R8 top word and range error", code_data, 32'hC0DE_003F);
        // R2 R3 R5 three-word macro on entry 3, launch held 3 cycles
        put(BASE + 6, 32'hA0, 0); put(BASE + 7, 32'hA1, 0); put(BASE + 7, 32'hA2, 1); idle();
        #1 chk(mac_offset == 5 && mac_count == 3, "R2 entry decode", {mac_offset, mac_count}, {6'd5, 6'd3});
        run_macro(3);
        // single-word macro on entry 9
        put(BASE + 18, 32'hB0, 1); idle();
        #1 chk(mac_offset == 40, "R7 second binding", mac_offset, 40);
        run_macro(0);
        // R2 odd start
        put(BASE + 7, 32'h5, 1); idle();
        #1 chk(err[1] && !mac_valid && in_ready, "R2 odd start", err, 5'h0A);
        // R4 sequence violation, then legal argument fires
        put(BASE + 6, 32'hC0, 0); put('h010, 32'hC1, 0); put(BASE + 9, 32'hC2, 0);
        idle();
        #1 chk(err[0] && !reg_we, "R4 illegal dropped", err, 5'h0B);
        put(BASE + 7, 32'hC3, 1); idle();
        #1 chk(mac_count == 2, "R4 pending kept", mac_count, 2);
        run_macro(1);
        // R6 unbound and out-of-range entries
        put(BASE + 32, 32'hD0, 1); idle();
        #1 chk(err[2] && !mac_valid && in_ready, "R6 unbound", err, 5'h0F);
        put(BASE + 200, 32'hD1, 0); put(BASE + 201, 32'hD2, 1); idle();
        #1 chk(!mac_valid && mac_count == 0, "R6 buffer emptied", mac_count, 0);
        // R9 overflow
        put(BASE + 6, 32'hE000, 0);
        for (int i = 1; i < 33; i++) put(BASE + 7, 32'hE000 + 32'(i), 0);
        put(BASE + 7, 32'hEFFF, 1); idle();
        #1 chk(err[4] && mac_count == 32, "R9 overflow", {err, mac_count}, {5'h1F, 6'd32});
        run_macro(0);
        repeat (3) @(negedge clk);
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            tests++; fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule